// File: doc/BRIEF.md
# External Interrupt Pin Vector Entry

This block is one entry of a processor-local interrupt vector table that serves a single external interrupt pin. Software programs a 32-bit configuration word holding the vector number, the delivery type, the pin polarity, the trigger style and a mask. The block brings the asynchronous pin into the clock domain, turns it into an active/inactive level according to the polarity, and then detects either an inactive-to-active transition or a sustained active level. When the entry is unmasked it presents a request to the core.

The request travels toward the core on a valid/ready stream that carries the vector and the delivery type. Once `req_valid` rises it stays high, and `req_vector` and `req_mode` stay unchanged, until the cycle in which `req_ready` is also high. That cycle is the acceptance. The core may hold `req_ready` low for as long as it needs, and nothing is lost while it waits. Two read-only bits report progress. Delivery status is high while a request is outstanding. Remote-IRR tracks fixed-mode level requests from acceptance until an end-of-interrupt strobe.

The parameter `EDGE_ONLY` builds the restricted variant used for the second pin. That variant never performs level-sensitive delivery.

Top module: `pin_vector_entry`

## Requirements
- R1: After reset the configuration word reads 0x00010000 (mask set, every other bit 0), and `req_valid` is 0.
- R2: The writable fields are: vector in bits 7:0, delivery type in bits 10:8, polarity in bit 13, trigger in bit 15 and mask in bit 16. Bits 31:17 and bit 11 always read 0. Bit 12 (delivery status) and bit 14 (remote-IRR) are read-only. Writes to all of these reserved and read-only bits are ignored.
- R3: Polarity bit 13 = 0 makes a high pin active. Polarity bit 13 = 1 makes a low pin active.
- R4: In edge behaviour, each inactive-to-active transition of the pin issues one request. `req_valid` rises on the third rising clock edge after the pin changes (two synchronizer stages, then the request register).
- R5: Delivery type codes are: 000 fixed, 010 system-management, 100 non-maskable, 101 init and 111 external-controller. Fixed mode follows trigger bit 15 (0 edge, 1 level). External-controller mode always behaves as level. System-management, non-maskable and init modes always behave as edge. In level behaviour a request is issued whenever the pin is active and nothing is outstanding.
- R6: While mask bit 16 is 1, no new request is issued. An edge that arrives while the entry is masked is discarded and does not produce a request after unmasking.
- R7: A presented request holds `req_valid`, `req_vector` and `req_mode` stable until it is accepted (`req_valid` and `req_ready` both high). An edge that arrives while a request is outstanding is discarded.
- R8: `req_mode` carries the delivery type code. `req_vector` carries the vector field for fixed and external-controller modes, and is 0 for system-management, non-maskable and init modes.
- R9: The delivery type codes 001, 011 and 110 never issue a request.
- R10: Delivery status bit 12 reads 1 exactly while `req_valid` is 1.
- R11: Remote-IRR bit 14 is set when a fixed-mode level request is accepted, and is cleared by `eoi`. While it is set, no new request is issued. Under any other mode or trigger it reads 0.
- R12: With `EDGE_ONLY` = 1, trigger bit 15 reads 0 and writes to it are ignored. External-controller mode then behaves as edge, so holding the pin active after an acceptance issues no second request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word and status readback |
| pin_async | input | 1 | External interrupt pin, asynchronous to `clk` |
| eoi | input | 1 | End-of-interrupt strobe, one cycle |
| req_valid | output | 1 | Request toward the core is valid |
| req_ready | input | 1 | Core accepts the request |
| req_vector | output | 8 | Vector carried with the request |
| req_mode | output | 3 | Delivery type carried with the request |

## Verification
The bench builds two instances. The first uses the defaults (`EDGE_ONLY` = 0, `SYNC_STAGES` = 2), which brings every delivery type, both polarities, level behaviour, remote-IRR blocking and the three-edge pin latency within reach. The second sets `EDGE_ONLY` = 1, which brings the restricted variant within reach: the trigger bit is dropped, and external-controller mode is forced to edge behaviour while the pin is held active.

// File: rtl/pve_pkg.sv
package pve_pkg;
  localparam int REG_W     = 32;
  localparam int VEC_W     = 8;
  localparam int MODE_W    = 3;
  localparam int F_MODE_LO = 8;
  localparam int F_DSTAT   = 12;
  localparam int F_POL     = 13;
  localparam int F_RIRR    = 14;
  localparam int F_TRIG    = 15;
  localparam int F_MASK    = 16;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'b000,
    DM_SMI    = 3'b010,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_EXTINT = 3'b111
  } dmode_e;

  function automatic logic mode_legal(logic [MODE_W-1:0] m);
    case (m)
      DM_FIXED, DM_SMI, DM_NMI, DM_INIT, DM_EXTINT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_novec(logic [MODE_W-1:0] m);
    return (m == DM_SMI) || (m == DM_NMI) || (m == DM_INIT);
  endfunction
endpackage

// File: rtl/pve_sync.sv
module pve_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/pve_cfg_reg.sv
module pve_cfg_reg
  import pve_pkg::*;
#(
  parameter bit EDGE_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [VEC_W-1:0]  vec,
  output logic [MODE_W-1:0] mode,
  output logic              pol,
  output logic              trig,
  output logic              mask
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[REG_W-1:F_MASK+1], wdata[F_RIRR],
                          wdata[F_DSTAT:F_MODE_LO+MODE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec  <= '0;
      mode <= '0;
      pol  <= 1'b0;
      mask <= 1'b1;
    end else if (we) begin
      vec  <= wdata[VEC_W-1:0];
      mode <= wdata[F_MODE_LO +: MODE_W];
      pol  <= wdata[F_POL];
      mask <= wdata[F_MASK];
    end
  end

  generate
    if (EDGE_ONLY) begin : g_no_trig
      logic unused_trig;
      assign unused_trig = wdata[F_TRIG];
      assign trig = 1'b0;
    end else begin : g_trig
      logic trig_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  trig_q <= 1'b0;
        else if (we) trig_q <= wdata[F_TRIG];
      end
      assign trig = trig_q;
    end
  endgenerate
endmodule

// File: rtl/pve_event.sv
module pve_event #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic pol,
  output logic active,
  output logic rise
);
  logic pin_s;
  logic prev_active;

  pve_sync #(.STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_async),
    .q     (pin_s)
  );

  assign active = pin_s ^ pol;
  assign rise   = active & ~prev_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_active <= 1'b0;
    else        prev_active <= active;
  end
endmodule

// File: rtl/pve_deliver.sv
module pve_deliver
  import pve_pkg::*;
#(
  parameter bit EDGE_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  vec,
  input  logic [MODE_W-1:0] mode,
  input  logic              trig,
  input  logic              mask,
  input  logic              active,
  input  logic              rise,
  input  logic              eoi,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_vector,
  output logic [MODE_W-1:0] req_mode,
  output logic              rirr
);
  logic fixed_lvl, lvl, fire, accept, lvl_q;

  assign fixed_lvl = !EDGE_ONLY && (mode == DM_FIXED) && trig;
  assign lvl       = fixed_lvl || (!EDGE_ONLY && (mode == DM_EXTINT));
  assign fire      = !mask && mode_legal(mode) && !req_valid &&
                     (lvl ? (active && !rirr) : rise);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_vector <= '0;
      req_mode   <= '0;
      lvl_q      <= 1'b0;
    end else if (fire) begin
      req_valid  <= 1'b1;
      req_vector <= mode_novec(mode) ? '0 : vec;
      req_mode   <= mode;
      lvl_q      <= fixed_lvl;
    end else if (accept) begin
      req_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rirr <= 1'b0;
    else if (accept && lvl_q)   rirr <= 1'b1;
    else if (eoi || !fixed_lvl) rirr <= 1'b0;
  end
endmodule

// File: rtl/pin_vector_entry.sv
module pin_vector_entry
  import pve_pkg::*;
#(
  parameter bit EDGE_ONLY   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              pin_async,
  input  logic              eoi,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [VEC_W-1:0]  req_vector,
  output logic [MODE_W-1:0] req_mode
);
  logic [VEC_W-1:0]  vec;
  logic [MODE_W-1:0] mode;
  logic pol, trig, mask, active, rise, rirr;

  pve_cfg_reg #(.EDGE_ONLY(EDGE_ONLY)) u_cfg (
    .clk (clk), .rst_n (rst_n), .we (cfg_we), .wdata (cfg_wdata),
    .vec (vec), .mode (mode), .pol (pol), .trig (trig), .mask (mask)
  );

  pve_event #(.STAGES(SYNC_STAGES)) u_evt (
    .clk (clk), .rst_n (rst_n), .pin_async (pin_async), .pol (pol),
    .active (active), .rise (rise)
  );

  pve_deliver #(.EDGE_ONLY(EDGE_ONLY)) u_dlv (
    .clk (clk), .rst_n (rst_n), .vec (vec), .mode (mode), .trig (trig),
    .mask (mask), .active (active), .rise (rise), .eoi (eoi),
    .req_ready (req_ready), .req_valid (req_valid),
    .req_vector (req_vector), .req_mode (req_mode), .rirr (rirr)
  );

  always_comb begin
    cfg_rdata                       = '0;
    cfg_rdata[VEC_W-1:0]            = vec;
    cfg_rdata[F_MODE_LO +: MODE_W]  = mode;
    cfg_rdata[F_DSTAT]              = req_valid;
    cfg_rdata[F_POL]                = pol;
    cfg_rdata[F_RIRR]               = rirr;
    cfg_rdata[F_TRIG]               = trig;
    cfg_rdata[F_MASK]               = mask;
  end
endmodule

// File: rtl/pve_checker.sv
module pve_checker #(
  parameter bit EDGE_ONLY = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        eoi,
  input logic        req_valid,
  input logic        req_ready,
  input logic [7:0]  req_vector,
  input logic [2:0]  req_mode,
  input logic [31:0] cfg_rdata
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_vector) && $stable(req_mode));

  p_dstat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[12] == req_valid);

  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:17] == '0 && !cfg_rdata[11]);

  p_novec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_mode == 3'b010 || req_mode == 3'b100 || req_mode == 3'b101)
    |-> req_vector == 8'h00);

  p_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_mode != 3'b001 && req_mode != 3'b011 && req_mode != 3'b110));

  p_eoi_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !(req_valid && req_ready) |=> !cfg_rdata[14]);

  p_rirr_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[14] && !(req_valid && req_ready) |=> !cfg_rdata[14]);

  generate
    if (EDGE_ONLY) begin : g_edge_only
      p_no_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[15] && !cfg_rdata[14]);
    end
  endgenerate
endmodule

bind pin_vector_entry pve_checker #(.EDGE_ONLY(EDGE_ONLY)) u_chk (
  .clk (clk), .rst_n (rst_n), .eoi (eoi), .req_valid (req_valid),
  .req_ready (req_ready), .req_vector (req_vector), .req_mode (req_mode),
  .cfg_rdata (cfg_rdata)
);

// File: tb/pin_vector_entry_test.sv
module pin_vector_entry_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        we_a = 0, pin_a = 0, eoi_a = 0, rdy_a = 0;
  logic [31:0] wd_a = 0, rd_a;
  logic        vld_a;
  logic [7:0]  vec_a;
  logic [2:0]  mode_a;

  logic        we_b = 0, pin_b = 0, eoi_b = 0, rdy_b = 0;
  logic [31:0] wd_b = 0, rd_b;
  logic        vld_b;
  logic [7:0]  vec_b;
  logic [2:0]  mode_b;

  pin_vector_entry uut (
    .clk (clk), .rst_n (rst_n), .cfg_we (we_a), .cfg_wdata (wd_a), .cfg_rdata (rd_a),
    .pin_async (pin_a), .eoi (eoi_a), .req_valid (vld_a), .req_ready (rdy_a),
    .req_vector (vec_a), .req_mode (mode_a)
  );

  pin_vector_entry #(.EDGE_ONLY(1'b1)) uut_b (
    .clk (clk), .rst_n (rst_n), .cfg_we (we_b), .cfg_wdata (wd_b), .cfg_rdata (rd_b),
    .pin_async (pin_b), .eoi (eoi_b), .req_valid (vld_b), .req_ready (rdy_b),
    .req_vector (vec_b), .req_mode (mode_b)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // cfg word, request expected, expected vector, remote-IRR after acceptance
  localparam int NV = 8;
  localparam logic [31:0] TV_CFG [NV] = '{
    32'h0000_0041,  // fixed edge, high active
    32'h0000_8052,  // fixed level
    32'h0000_2433,  // nmi, low active
    32'h0000_8211,  // smi, trigger bit forced to edge
    32'h0000_0720,  // external controller, level
    32'h0000_0399,  // illegal code 011
    32'h0001_0077,  // masked fixed
    32'h0000_0505   // init
  };
  localparam logic       TV_REQ  [NV] = '{1, 1, 1, 1, 1, 0, 0, 1};
  localparam logic [7:0] TV_VEC  [NV] = '{8'h41, 8'h52, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00};
  localparam logic       TV_RIRR [NV] = '{0, 1, 0, 0, 0, 0, 0, 0};

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_a(input logic [31:0] d);
    we_a = 1; wd_a = d; tick(); we_a = 0;
  endtask

  task automatic wr_b(input logic [31:0] d);
    we_b = 1; wd_b = d; tick(); we_b = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 reset word", rd_a, 32'h0001_0000);
    check("R1 reset valid", {31'b0, vld_a}, 32'h0);
    rst_n = 1;
    tick();

    // R2 reserved and read-only bits ignored
    wr_a(32'hFFFF_FFFF);
    check("R2 write all ones", rd_a, 32'h0001_A7FF);
    wr_a(32'h0001_0000);
    check("R2 write back", rd_a, 32'h0001_0000);

    // Vector table: R3 R4 R5 R8 R9 R6 R11
    for (int i = 0; i < NV; i++) begin
      logic [31:0] c;
      logic pol;
      c = TV_CFG[i];
      pol = c[13];
      pin_a = pol;
      wr_a(c | 32'h0001_0000);
      repeat (4) tick();
      wr_a(c);
      check("R2 readback", rd_a, c);
      tick();
      pin_a = ~pol;                       // R3 active level follows polarity
      tick(); tick();
      check("R4 no request before third edge", {31'b0, vld_a}, 32'h0);
      tick();
      check("R4 R5 R6 R9 request raised", {31'b0, vld_a}, {31'b0, TV_REQ[i]});
      if (TV_REQ[i]) begin
        check("R8 vector", {24'b0, vec_a}, {24'b0, TV_VEC[i]});
        check("R8 mode", {29'b0, mode_a}, {29'b0, c[10:8]});
        rdy_a = 1; tick(); rdy_a = 0;
        check("R7 accepted", {31'b0, vld_a}, 32'h0);
        check("R11 remote-IRR", {31'b0, rd_a[14]}, {31'b0, TV_RIRR[i]});
      end
      pin_a = pol;
      rdy_a = 1;
      repeat (4) tick();
      eoi_a = 1; tick(); eoi_a = 0;
      repeat (2) tick();
      rdy_a = 0;
      tick();
    end

    // R6 edge while masked is discarded
    pin_a = 0;
    wr_a(32'h0001_0061);
    repeat (4) tick();
    pin_a = 1;
    repeat (4) tick();
    wr_a(32'h0000_0061);
    repeat (4) tick();
    check("R6 masked edge discarded", {31'b0, vld_a}, 32'h0);
    pin_a = 0; repeat (4) tick();
    pin_a = 1; repeat (3) tick();
    check("R6 unmasked edge", {31'b0, vld_a}, 32'h1);

    // R7 R10 back-pressure
    for (int k = 0; k < 8; k++) begin
      check("R7 held valid", {31'b0, vld_a}, 32'h1);
      check("R7 held vector", {24'b0, vec_a}, 32'h61);
      check("R10 status while pending", {31'b0, rd_a[12]}, 32'h1);
      pin_a = k[0];                       // edges while outstanding
      tick();
    end
    pin_a = 1;
    repeat (4) tick();
    rdy_a = 1; tick(); rdy_a = 0;
    check("R10 status after accept", {31'b0, rd_a[12]}, 32'h0);
    repeat (4) tick();
    check("R7 edge while outstanding discarded", {31'b0, vld_a}, 32'h0);
    pin_a = 0; repeat (4) tick();

    // R11 remote-IRR blocks level request until eoi
    wr_a(32'h0001_8044);
    repeat (4) tick();
    wr_a(32'h0000_8044);
    pin_a = 1; repeat (3) tick();
    check("R11 level request", {31'b0, vld_a}, 32'h1);
    rdy_a = 1; tick(); rdy_a = 0;
    repeat (6) tick();
    check("R11 blocked while set", {31'b0, vld_a}, 32'h0);
    check("R11 flag set", {31'b0, rd_a[14]}, 32'h1);
    eoi_a = 1; tick(); eoi_a = 0;
    check("R11 flag cleared", {31'b0, rd_a[14]}, 32'h0);
    tick();
    check("R11 request after eoi", {31'b0, vld_a}, 32'h1);
    pin_a = 0;
    rdy_a = 1; repeat (4) tick(); rdy_a = 0;
    eoi_a = 1; tick(); eoi_a = 0;

    // R12 edge-only variant
    pin_b = 0;
    wr_b(32'h0001_8720);
    repeat (4) tick();
    wr_b(32'h0000_8720);
    check("R12 trigger bit dropped", rd_b, 32'h0000_0720);
    pin_b = 1; repeat (3) tick();
    check("R12 edge request", {31'b0, vld_b}, 32'h1);
    check("R12 vector", {24'b0, vec_b}, 32'h20);
    rdy_b = 1; tick(); rdy_b = 0;
    repeat (6) tick();
    check("R12 no level repeat", {31'b0, vld_b}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule